// File: doc/BRIEF.md
# Hot-Plug-Detect Pulse Classifier

This block watches the hot-plug-detect level coming from a display sink and turns its changes into four events: a sink arriving (plug), a sink leaving (unplug), a brief low pulse requesting attention (short interrupt) and a medium-length low dip (replug). The input is first synchronized. A state machine then times how long the level stays high or low, in ticks of a prescaled timing strobe that software can switch on and off. Each event sets a sticky pending bit.

A small register interface gives software a raw status view and a filtered status view. Both carry the pending events and two live informational bits: the synchronized level and a connected flag. Software also sees an event enable mask, a write-one-to-clear acknowledge and the timer control. One interrupt output is raised whenever an enabled event is pending. Thresholds are parameters counted in strobe ticks. The defaults give 1 µs ticks at 250 MHz, a 2 ms short-pulse limit and a 100 ms settle time.

The state machine has four states. `ST_DISC` means disconnected and low. `ST_QUAL` means high and qualifying. `ST_CONN` means connected and high. `ST_PULSE` means connected and low while the pulse is measured. Its transitions:
- rise: `ST_DISC`→`ST_QUAL`
- drop-out: `ST_QUAL`→`ST_DISC`
- qualify: `ST_QUAL`→`ST_CONN`, raises plug
- dip: `ST_CONN`→`ST_PULSE`
- short return: `ST_PULSE`→`ST_CONN`, raises short interrupt
- late return: `ST_PULSE`→`ST_CONN`, raises replug
- give-up: `ST_PULSE`→`ST_DISC`, raises unplug

Top module: `hpd_classifier`

## Requirements
- R1: The input passes through a two-flop synchronizer. Status bit 4 reports the synchronized level, in both the raw view (address 0) and the filtered view (address 1).
- R2: From disconnected, a plug event is raised when the level stays high for LONG_TICKS consecutive ticks. A plug event is status bit 0 and sets the connected flag, status bit 5. A high spell that ends sooner raises nothing.
- R3: While connected, a low pulse that returns high after fewer than SHORT_TICKS ticks raises the short-interrupt event, status bit 1.
- R4: While connected, a low pulse that returns high after at least SHORT_TICKS ticks but before LONG_TICKS ticks raises the replug event, status bit 2. The connected flag stays set.
- R5: While connected, a level that stays low for LONG_TICKS ticks raises the unplug event, status bit 3, and clears the connected flag.
- R6: Ticks are produced only while bit 0 of the timer control register (address 4) is set. While it is clear, duration counts are frozen and no plug or unplug event is raised. A pulse ending during that time is classified by the count it has reached.
- R7: A pending bit stays set until it is acknowledged. A repeat of the same event while it is pending leaves the bit at one.
- R8: Writing the acknowledge register (address 3) clears only the pending bits written as one. The informational bits 4 and 5 are not affected. An event arriving in the same cycle as its acknowledge stays pending.
- R9: After reset the mask register (address 2, bits 3:0) is zero, so the interrupt output stays low until software unmasks an event.
- R10: The filtered view shows the pending bits ANDed with the mask in bits 3:0 and passes bits 4 and 5 through unchanged.
- R11: The interrupt output is a register holding the OR of pending AND mask, one cycle after that value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_in | input | 1 | Raw hot-plug-detect level from the sink |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 4 | Register write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| irq_o | output | 1 | Interrupt, high while an enabled event is pending |

## Verification
A level change reaches the state machine three clock edges after it is driven: two synchronizer flops and the state register. The event pulse appears on that third edge, the pending bit one edge later and the interrupt one edge after that. Pulse durations are quantized to ticks, so the bench chooses low and high spells that sit several ticks away from each threshold. It then reads the sticky status only after a settle time that is well past all of these stages. The interrupt lag is checked cycle by cycle around a mask write: the output is sampled on the falling edge after the write edge and again one cycle later.

// File: rtl/hpd_cls_pkg.sv
package hpd_cls_pkg;
    localparam int EVT_W  = 4;
    localparam int INFO_W = 2;
    localparam int ADDR_W = 3;

    // event bit positions in the status field
    localparam int EV_PLUG   = 0;
    localparam int EV_IRQ    = 1;
    localparam int EV_REPLUG = 2;
    localparam int EV_UNPLUG = 3;

    localparam logic [ADDR_W-1:0] ADR_RAW  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FILT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_ACK  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_TMR  = 3'd4;

    typedef enum logic [1:0] {
        ST_DISC,
        ST_QUAL,
        ST_CONN,
        ST_PULSE
    } link_st_e;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/hpd_tick.sv
module hpd_tick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pre <= '0;
        else if (!en)         pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                  pre <= pre + 1'b1;
    end

    assign tick = en && (pre == LAST);
endmodule

// File: rtl/hpd_fsm.sv
module hpd_fsm
    import hpd_cls_pkg::*;
#(
    parameter int SHORT_TICKS = 2000,
    parameter int LONG_TICKS  = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             tick,
    output logic [EVT_W-1:0] evt,
    output logic             conn
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LONG_LAST = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_TICKS);

    link_st_e         state, nxt;
    logic [CW-1:0]    cnt;
    logic [EVT_W-1:0] evt_d;

    // next state and event decode
    always_comb begin
        nxt   = state;
        evt_d = '0;
        unique case (state)
            ST_DISC: begin
                if (level) nxt = ST_QUAL;
            end
            ST_QUAL: begin
                if (!level) begin
                    nxt = ST_DISC;
                end else if (tick && cnt == LONG_LAST) begin
                    nxt            = ST_CONN;
                    evt_d[EV_PLUG] = 1'b1;
                end
            end
            ST_CONN: begin
                if (!level) nxt = ST_PULSE;
            end
            ST_PULSE: begin
                if (level) begin
                    nxt = ST_CONN;
                    if (cnt < SHORT_LIM) evt_d[EV_IRQ]    = 1'b1;
                    else                 evt_d[EV_REPLUG] = 1'b1;
                end else if (tick && cnt == LONG_LAST) begin
                    nxt              = ST_DISC;
                    evt_d[EV_UNPLUG] = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DISC;
        else        state <= nxt;
    end

    // duration counter, restarted on every transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (nxt != state)
            cnt <= '0;
        else if (tick && (state == ST_QUAL || state == ST_PULSE))
            cnt <= cnt + 1'b1;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt  <= '0;
            conn <= 1'b0;
        end else begin
            evt  <= evt_d;
            conn <= (nxt == ST_CONN) || (nxt == ST_PULSE);
        end
    end
endmodule

// File: rtl/hpd_regs.sv
module hpd_regs
    import hpd_cls_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt,
    input  logic              level,
    input  logic              conn,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [EVT_W-1:0]  wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [EVT_W-1:0]  pend,
    output logic [EVT_W-1:0]  mask,
    output logic [EVT_W-1:0]  ack_vec,
    output logic              tmr_en,
    output logic              irq_o
);
    logic [INFO_W-1:0] info;

    assign ack_vec = (wr_en && addr == ADR_ACK) ? wr_data : '0;
    assign info    = {conn, level};

    // sticky pending bits: a new event wins over its acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~ack_vec) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask   <= '0;
            tmr_en <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADR_MASK) mask   <= wr_data;
            if (addr == ADR_TMR)  tmr_en <= wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(pend & mask);
    end

    always_comb begin
        unique case (addr)
            ADR_RAW:  rd_data = DATA_W'({info, pend});
            ADR_FILT: rd_data = DATA_W'({info, pend & mask});
            ADR_MASK: rd_data = DATA_W'(mask);
            ADR_TMR:  rd_data = DATA_W'(tmr_en);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/hpd_classifier.sv
module hpd_classifier
    import hpd_cls_pkg::*;
#(
    parameter int TICK_DIV    = 250,
    parameter int SHORT_TICKS = 2000,
    parameter int LONG_TICKS  = 100000,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_in,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [3:0]        wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    logic             lvl_s;
    logic             tick_w;
    logic             tmr_en_w;
    logic             conn_w;
    logic [EVT_W-1:0] evt_w;
    logic [EVT_W-1:0] pend_w;
    logic [EVT_W-1:0] mask_w;
    logic [EVT_W-1:0] ack_w;

    hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(hpd_in), .q(lvl_s)
    );

    hpd_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(tmr_en_w), .tick(tick_w)
    );

    hpd_fsm #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .level(lvl_s), .tick(tick_w),
        .evt(evt_w), .conn(conn_w)
    );

    hpd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .evt(evt_w), .level(lvl_s), .conn(conn_w),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .pend(pend_w), .mask(mask_w), .ack_vec(ack_w), .tmr_en(tmr_en_w),
        .irq_o(irq_o)
    );
endmodule

// File: rtl/hpd_classifier_chk.sv
module hpd_classifier_chk
    import hpd_cls_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             conn,
    input logic [EVT_W-1:0] evt,
    input logic [EVT_W-1:0] pend,
    input logic [EVT_W-1:0] mask,
    input logic [EVT_W-1:0] ack_vec,
    input logic             irq_o
);
    // R2
    plug_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EV_PLUG] |-> $past(tick) && $rose(conn));

    // R5
    unplug_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EV_UNPLUG] |-> $past(tick) && $fell(conn));

    // R4
    pulse_keeps_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[EV_IRQ] || evt[EV_REPLUG]) |-> conn && $past(conn));

    // R3
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt));

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & ~pend & ~$past(ack_vec)) == '0);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & $past(ack_vec) & ~$past(evt)) == '0);

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(pend & mask)));
endmodule

bind hpd_classifier hpd_classifier_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .conn(conn_w), .evt(evt_w),
    .pend(pend_w), .mask(mask_w), .ack_vec(ack_w), .irq_o(irq_o)
);

// File: tb/hpd_classifier_test.sv
module hpd_classifier_test;
    localparam int TDIV = 4;
    localparam int SH   = 5;
    localparam int LG   = 20;
    localparam int DW   = 8;
    localparam int NVEC = 5;
    // {low cycles, expected event bits}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'd6,   4'b0010},
        {8'd12,  4'b0010},
        {8'd32,  4'b0100},
        {8'd60,  4'b0100},
        {8'd120, 4'b1001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hpd_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = 3'd0;
    logic [3:0]    wr_data = 4'd0;
    logic [DW-1:0] rd_data;
    logic          irq_o;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    hpd_classifier #(.TICK_DIV(TDIV), .SHORT_TICKS(SH), .LONG_TICKS(LG),
                     .SYNC_STAGES(2), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .hpd_in(hpd_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        hold(5);
        rst_n = 1'b1;
        hold(2);

        // R9 R1 reset state
        reg_rd(3'd0, v); check("R1 raw after reset", v, 8'h00);
        reg_rd(3'd2, v); check("R9 mask after reset", v, 8'h00);
        reg_rd(3'd4, v); check("R6 timer off after reset", v, 8'h00);
        check("R9 irq after reset", {7'd0, irq_o}, 8'h00);

        // R6 timer disabled: level seen, no plug
        hpd_in = 1'b1;
        hold(150);
        reg_rd(3'd0, v); check("R6 no plug while timer off", v, 8'h10);

        // R2 plug once enabled; masked so irq stays low (R9)
        reg_wr(3'd4, 4'h1);
        hold(110);
        reg_rd(3'd0, v); check("R2 plug raw", v, 8'h31);
        reg_rd(3'd1, v); check("R10 filtered masked", v, 8'h30);
        check("R9 irq masked", {7'd0, irq_o}, 8'h00);

        // R8 ack all leaves info bits
        reg_wr(3'd3, 4'hF);
        reg_rd(3'd0, v); check("R8 ack keeps info", v, 8'h30);

        // table walk: pulse classes R3 R4 R5
        reg_wr(3'd2, 4'hF);
        for (int i = 0; i < NVEC; i++) begin
            reg_wr(3'd3, 4'hF);
            hpd_in = 1'b0;
            hold(int'(VEC[i][11:4]));
            hpd_in = 1'b1;
            hold(120);
            reg_rd(3'd0, v); check("R3 R4 R5 pulse class raw", v, {4'h3, VEC[i][3:0]});
            reg_rd(3'd1, v); check("R10 filtered all enabled", v, {4'h3, VEC[i][3:0]});
            check("R11 irq enabled", {7'd0, irq_o}, 8'h01);
        end

        // R7 sticky repeat
        reg_wr(3'd3, 4'hF);
        for (int k = 0; k < 2; k++) begin
            hpd_in = 1'b0; hold(8);
            hpd_in = 1'b1; hold(20);
        end
        reg_rd(3'd0, v); check("R7 repeated short stays one", v, 8'h32);

        // R8 partial ack
        hpd_in = 1'b0; hold(40);
        hpd_in = 1'b1; hold(20);
        reg_rd(3'd0, v); check("R4 replug added", v, 8'h36);
        reg_wr(3'd3, 4'h2);
        reg_rd(3'd0, v); check("R8 partial ack", v, 8'h34);

        // R11 one-cycle lag after mask write
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd2; wr_data = 4'h0;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 irq lags mask", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        check("R11 irq drops", {7'd0, irq_o}, 8'h00);

        // R10 filtered view per mask
        reg_rd(3'd1, v); check("R10 filtered mask zero", v, 8'h30);
        reg_wr(3'd2, 4'h4);
        reg_rd(3'd1, v); check("R10 filtered replug enabled", v, 8'h34);
        reg_wr(3'd2, 4'h1);
        reg_rd(3'd1, v); check("R10 filtered plug enabled", v, 8'h30);

        // R6 frozen count: long low with timer off ends as short pulse
        reg_wr(3'd3, 4'hF);
        reg_wr(3'd4, 4'h0);
        hpd_in = 1'b0; hold(200);
        reg_rd(3'd0, v); check("R6 no unplug while timer off", v, 8'h20);
        hpd_in = 1'b1; hold(10);
        reg_rd(3'd0, v); check("R6 frozen count gives short", v, 8'h32);
        reg_wr(3'd4, 4'h1);

        // R5 unplug then R2 short high spell gives nothing
        reg_wr(3'd3, 4'hF);
        hpd_in = 1'b0; hold(120);
        reg_rd(3'd0, v); check("R5 unplug clears connected", v, 8'h08);
        reg_wr(3'd3, 4'hF);
        hpd_in = 1'b1; hold(40);
        hpd_in = 1'b0; hold(20);
        reg_rd(3'd0, v); check("R2 short high no plug", v, 8'h00);

        finish_run();
    end
endmodule